// File: doc/BRIEF.md
# Dual Programmable Audio Bit-Clock Divider

This block holds two independent rate generators, A and B. Each one picks one of four synchronous audio master-clock strobe inputs and divides that strobe stream by a programmable ratio. It then emits a one-cycle enable pulse in the system-clock domain. Each ratio comes from a two-stage divider. A prescaler first divides by 2, 8, 32 or 128. A counter then divides the prescaler output by a further N+1.

Software programs the block through a small synchronous write port and a combinational read port, both addressed by two bits. Address 0 holds the divider word for generator A. Address 1 holds the divider word for generator B. Address 2 is the control word. It holds the source select of each generator and the bit that picks which generator drives the shared clock-out pin. Writing a divider word or the control word restarts the affected generators, so a new ratio or source applies from the next strobe on.

Top module: `dual_rate_divider`

## Requirements
- R1: A divider word is 10 bits wide. Bits 9:8 hold the prescale code p and bits 7:0 hold the count N. A word reads back through the read port with bits 31:10 zero. Address 0 is the A word, address 1 the B word and address 2 the control word. Address 3 reads zero, and writes to it change nothing.
- R2: A generator raises its tick output for exactly one cycle for every (2 << 2p) * (N+1) strobes of its selected source. The tick is high in the cycle after the clock edge that sampled the completing strobe.
- R3: After reset both divider words read 2 (p = 0, N = 2, a ratio of 6) and the control word reads 0.
- R4: In the control word, bits 22:20 are the source select of generator A, bits 18:16 the source select of generator B, and bit 31 the output select. All other bits read as zero whatever is written.
- R5: Source select code 0 picks src_stb[0] (input A), code 1 picks src_stb[1] (input B), code 2 picks src_stb[3] (internal input I) and code 4 picks src_stb[2] (input C). Codes 3, 5, 6 and 7 select no source, and that generator never ticks.
- R6: clk_out equals tick_b in the same cycle when control bit 31 is set, and equals tick_a when it is clear.
- R7: A write to a generator's divider word restarts that generator, and a control-word write restarts both. A restart clears the prescaler and counter, overrides a strobe in the same cycle, and leaves the tick low in the following cycle. The next tick needs a full ratio of fresh strobes.
- R8: Strobes on inputs a generator has not selected do not advance that generator. The two generators count independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for addr, combinational |
| src_stb | input | 4 | Source strobes: [0] input A, [1] input B, [2] input C, [3] internal input I |
| tick_a | output | 1 | One-cycle output pulse of generator A |
| tick_b | output | 1 | One-cycle output pulse of generator B |
| clk_out | output | 1 | Shared output, carrying tick_a or tick_b |

## Verification
The bench sweeps every prescale code against several counts on both generators at once. It feeds sparse, overlapping strobe patterns on selected and unselected inputs. A prescaler that is off by one, or a wrong power of four, shifts every tick position. A generator that counts a neighbour's input ticks early. All eight select codes are paired with each of the four inputs, which exposes the non-sequential mapping of inputs C and I: a straight binary decode would tick on the wrong input for codes 2 and 4, and would tick on reserved codes. A restart in the middle of a count catches a design that keeps stale prescaler or counter state. Such a design ticks after fewer than a full ratio of strobes once the write lands.

// File: rtl/drd_pkg.sv
package drd_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int PRE_W     = 2;
    localparam int CNT_W     = 8;
    localparam int WORD_W    = PRE_W + CNT_W;
    localparam int SEL_W     = 3;
    localparam int NUM_SRC   = 4;
    localparam int NUM_GEN   = 2;
    localparam int OUT_BIT   = 31;
    localparam int SEL_LSB0  = 20;
    localparam int SEL_STEP  = 4;

    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(NUM_GEN);

    localparam logic [SEL_W-1:0] CODE_A = 3'd0;
    localparam logic [SEL_W-1:0] CODE_B = 3'd1;
    localparam logic [SEL_W-1:0] CODE_I = 3'd2;
    localparam logic [SEL_W-1:0] CODE_C = 3'd4;

    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_C = 2;
    localparam int IDX_I = 3;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } div_word_t;

    localparam div_word_t WORD_RST = '{pre: '0, cnt: CNT_W'(2)};

    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << OUT_BIT)
      | (DATA_W'((1 << SEL_W) - 1) << SEL_LSB0)
      | (DATA_W'((1 << SEL_W) - 1) << (SEL_LSB0 - SEL_STEP));
endpackage

// File: rtl/drd_regs.sv
module drd_regs
    import drd_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wr_data,
    output div_word_t [NUM_GEN-1:0]             word_o,
    output logic [NUM_GEN-1:0][SEL_W-1:0]       sel_o,
    output logic                                out_b_o,
    output logic [NUM_GEN-1:0]                  reload_o,
    output logic [DATA_W-1:0]                   rd_data
);
    typedef struct packed {
        div_word_t [NUM_GEN-1:0]          word;
        logic [NUM_GEN-1:0][SEL_W-1:0]    sel;
        logic                             out_b;
    } regs_t;

    localparam regs_t REGS_RST = '{word: {NUM_GEN{WORD_RST}}, sel: '0, out_b: 1'b0};

    regs_t r_d, r_q;
    logic [NUM_GEN-1:0] reload_d;

    always_comb begin
        r_d      = r_q;
        reload_d = '0;
        if (wr_en) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (addr == ADDR_W'(g)) begin
                    r_d.word[g] = wr_data[WORD_W-1:0];
                    reload_d[g] = 1'b1;
                end
            end
            if (addr == ADR_CTRL) begin
                for (int g = 0; g < NUM_GEN; g++) begin
                    r_d.sel[g] = wr_data[SEL_LSB0 - SEL_STEP*g +: SEL_W];
                end
                r_d.out_b = wr_data[OUT_BIT];
                reload_d  = '1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (addr == ADDR_W'(g)) begin
                rd_data[WORD_W-1:0] = r_q.word[g];
            end
        end
        if (addr == ADR_CTRL) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                rd_data[SEL_LSB0 - SEL_STEP*g +: SEL_W] = r_q.sel[g];
            end
            rd_data[OUT_BIT] = r_q.out_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign word_o   = r_q.word;
    assign sel_o    = r_q.sel;
    assign out_b_o  = r_q.out_b;
    assign reload_o = reload_d;
endmodule

// File: rtl/drd_src_mux.sv
module drd_src_mux
    import drd_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_stb,
    input  logic [SEL_W-1:0]   code,
    output logic               stb
);
    always_comb begin
        case (code)
            CODE_A:  stb = src_stb[IDX_A];
            CODE_B:  stb = src_stb[IDX_B];
            CODE_I:  stb = src_stb[IDX_I];
            CODE_C:  stb = src_stb[IDX_C];
            default: stb = 1'b0;
        endcase
    end
endmodule

// File: rtl/drd_divider.sv
module drd_divider #(
    parameter int PRE_BITS = 2,
    parameter int CNT_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic                reload,
    input  logic [PRE_BITS-1:0] pre_code,
    input  logic [CNT_BITS-1:0] count_n,
    output logic                tick
);
    localparam int MAX_CODE = (1 << PRE_BITS) - 1;
    localparam int PCNT_W   = 2*MAX_CODE + 1;

    typedef struct packed {
        logic [PCNT_W-1:0]   pre;
        logic [CNT_BITS-1:0] cnt;
        logic                tick;
    } div_t;

    div_t s_d, s_q;
    logic [PCNT_W-1:0] pre_last;

    // prescale ratio 2 << 2p, so the last prescaler state is that minus one
    always_comb pre_last = {PCNT_W{1'b1}} >> {~pre_code, 1'b0};

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (reload) begin
            s_d.pre = '0;
            s_d.cnt = '0;
        end else if (stb) begin
            if (s_q.pre == pre_last) begin
                s_d.pre = '0;
                if (s_q.cnt == count_n) begin
                    s_d.cnt  = '0;
                    s_d.tick = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/dual_rate_divider.sv
module dual_rate_divider
    import drd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0]  src_stb,
    output logic                tick_a,
    output logic                tick_b,
    output logic                clk_out
);
    div_word_t [NUM_GEN-1:0]       word;
    logic [NUM_GEN-1:0][SEL_W-1:0] sel;
    logic                          out_b;
    logic [NUM_GEN-1:0]            reload;
    logic [NUM_GEN-1:0]            gen_stb;
    logic [NUM_GEN-1:0]            tick;

    drd_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .word_o   (word),
        .sel_o    (sel),
        .out_b_o  (out_b),
        .reload_o (reload),
        .rd_data  (rd_data)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        drd_src_mux u_mux (
            .src_stb (src_stb),
            .code    (sel[g]),
            .stb     (gen_stb[g])
        );

        drd_divider #(
            .PRE_BITS (PRE_W),
            .CNT_BITS (CNT_W)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb      (gen_stb[g]),
            .reload   (reload[g]),
            .pre_code (word[g].pre),
            .count_n  (word[g].cnt),
            .tick     (tick[g])
        );
    end

    assign tick_a  = tick[0];
    assign tick_b  = tick[1];
    assign clk_out = out_b ? tick[1] : tick[0];
endmodule

// File: rtl/drd_checker.sv
module drd_checker
    import drd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic [NUM_SRC-1:0]  src_stb,
    input logic                tick_a,
    input logic                tick_b,
    input logic                clk_out
);
    // R2
    tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_a || tick_b) |-> $past(|src_stb));

    // R2
    tick_a_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a |=> !tick_a);

    // R2
    tick_b_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_b |=> !tick_b);

    // R7
    ctrl_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_CTRL) |=> (!tick_a && !tick_b));

    // R6
    clk_out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> (tick_a || tick_b));

    // R4
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADR_CTRL) |-> ((rd_data & ~CTRL_MASK) == '0));

    // R1
    word_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != ADR_CTRL) |-> (rd_data[DATA_W-1:WORD_W] == '0));
endmodule

bind dual_rate_divider drd_checker u_drd_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .rd_data (rd_data),
    .src_stb (src_stb),
    .tick_a  (tick_a),
    .tick_b  (tick_b),
    .clk_out (clk_out)
);

// File: tb/dual_rate_divider_bench.sv
module dual_rate_divider_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  src_stb = '0;
    logic        tick_a, tick_b, clk_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    int  div_a, div_b, cnt_a, cnt_b, idx_a, idx_b;
    bit  out_sel_b;

    dual_rate_divider u_dual_rate_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .src_stb (src_stb),
        .tick_a  (tick_a),
        .tick_b  (tick_b),
        .clk_out (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ratio_of(input logic [31:0] w);
        return (2 << (2 * int'(w[9:8]))) * (int'(w[7:0]) + 1);
    endfunction

    // R5 encoding: 0->[0], 1->[1], 2->[3], 4->[2], else none
    function automatic int src_of(input logic [2:0] code);
        case (code)
            3'd0: return 0;
            3'd1: return 1;
            3'd2: return 3;
            3'd4: return 2;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] s, input string req);
        bit ea, eb;
        @(negedge clk);
        src_stb = s;
        @(posedge clk);
        #2;
        ea = 1'b0;
        eb = 1'b0;
        if (idx_a >= 0 && s[idx_a]) begin cnt_a++; ea = (cnt_a % div_a == 0); end
        if (idx_b >= 0 && s[idx_b]) begin cnt_b++; eb = (cnt_b % div_b == 0); end
        check({req, " tick_a"}, 32'(tick_a), 32'(ea));
        check({req, " tick_b"}, 32'(tick_b), 32'(eb));
        check("R6 clk_out", 32'(clk_out), 32'(out_sel_b ? eb : ea));
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        src_stb = '0;
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        case (a)
            2'd0: begin div_a = ratio_of(d); cnt_a = 0; end
            2'd1: begin div_b = ratio_of(d); cnt_b = 0; end
            2'd2: begin
                idx_a = src_of(d[22:20]);
                idx_b = src_of(d[18:16]);
                out_sel_b = d[31];
                cnt_a = 0;
                cnt_b = 0;
            end
            default: ;
        endcase
        check("R7 no tick_a after write", 32'(tick_a), 32'(0));
        check("R7 no tick_b after write", 32'(tick_b), 32'(0));
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        src_stb = '0;
        addr    = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        div_a = 6; div_b = 6; cnt_a = 0; cnt_b = 0;
        idx_a = 0; idx_b = 0; out_sel_b = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R3 reset state
        check("R3 tick_a at reset", 32'(tick_a), 32'(0));
        rd(2'd0, 32'h2, "R3 word A reset");
        rd(2'd1, 32'h2, "R3 word B reset");
        rd(2'd2, 32'h0, "R3 control reset");
        for (int i = 0; i < 14; i++) step(4'b0001, "R3 default ratio 6");

        // R1 / R4 register fields and reserved bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h0000_03FF, "R1 word A masked");
        wr(2'd1, 32'h0000_0155);
        rd(2'd1, 32'h0000_0155, "R1 word B readback");
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'h8077_0000, "R4 control masked");
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 32'h0, "R1 address 3 reads zero");
        rd(2'd0, 32'h0000_03FF, "R1 address 3 write ignored A");
        rd(2'd1, 32'h0000_0155, "R1 address 3 write ignored B");
        rd(2'd2, 32'h8077_0000, "R1 address 3 write ignored ctrl");

        // R2 / R8 sweep: every prescale code, several counts, both generators
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                int n;
                int len;
                logic [3:0] s;
                n = (k == 3) ? 7 : k;
                wr(2'd0, 32'((p << 8) | n));
                wr(2'd1, 32'(((3 - p) << 8) | (n + 1)));
                // A from input A, B from input C; output select alternates
                wr(2'd2, ((k % 2) ? 32'h8000_0000 : 32'h0) | 32'h0004_0000);
                len = 2 * ((div_a > div_b) ? div_a : div_b) + 3;
                for (int i = 0; i < len; i++) begin
                    // R8: inputs B and I toggle too, but are not selected
                    s[0] = (i % 3 != 1);
                    s[1] = (i % 5 == 0);
                    s[2] = (i % 2 == 0);
                    s[3] = (i % 7 != 3);
                    step(s, "R2 R8 sweep");
                end
            end
        end

        // R5 every select code against every input
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        for (int c = 0; c < 8; c++) begin
            wr(2'd2, (32'(c & 1) << 31) | (32'(c) << 20) | (32'(7 - c) << 16));
            for (int j = 0; j < 4; j++) begin
                for (int i = 0; i < 5; i++) step(4'(1 << j), "R5 source code");
            end
        end

        // R7 restart in the middle of a count
        wr(2'd2, 32'h0000_0000);
        wr(2'd0, 32'h2);
        wr(2'd1, 32'h101);
        for (int i = 0; i < 4; i++) step(4'b0001, "R7 before restart");
        wr(2'd0, 32'h2);
        for (int i = 0; i < 8; i++) step(4'b0001, "R7 after word restart");
        // R7 strobe in the write cycle is overridden by the restart
        @(negedge clk);
        src_stb = 4'b0001;
        wr_en   = 1'b1;
        addr    = 2'd2;
        wr_data = 32'h0;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        cnt_a = 0;
        cnt_b = 0;
        check("R7 restart beats strobe", 32'(tick_a), 32'(0));
        for (int i = 0; i < 40; i++) step(4'b0001, "R7 after control restart");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule